// File: doc/BRIEF.md
# Pipelined Four-Tap Symbol Match Counter

The block scores a stream of symbols against a stored four-symbol pattern. Symbols arrive one per qualified cycle and step through a short history window. Each tap compares one window position against its own reference symbol. An exact match contributes 1 and a mismatch contributes 0. Every accepted symbol produces one count, from 0 to 4, of how many taps agree. Tap 0 sees the newest symbol, tap 1 the symbol before it, and so on, so the count for symbol t is `sum_k (x[t-k] == ref[k])`.

The comparisons and the additions are spread over separate register stages. No clocked path holds more than one comparator or one narrow adder. The price is a fixed latency, and a valid flag travels alongside the count. Reference symbols are written through a small load port while the stream is idle.

Top module: `pattern_corr`

## Requirements
- R1: For each accepted symbol x[t], `y_cnt_o` equals the number of taps k in 0..3 for which x[t-k] equals reference k exactly. Tap 0 holds the newest symbol.
- R2: The count for a symbol sampled on rising edge n (with `x_valid_i` high) appears with `y_valid_o` high right after edge n+3.
- R3: `y_valid_o` is high exactly once for each accepted symbol and is low in every other cycle.
- R4: Cycles with `x_valid_i` low do not advance the history window. Idle gaps between symbols leave the counts unchanged.
- R5: When `ref_we_i` is high and `x_valid_i` is low, `ref_sym_i` is written to tap `ref_idx_i`, where index 0 is the newest-symbol tap. Symbols accepted afterwards are compared against the new value.
- R6: A reference write request made while `x_valid_i` is high is ignored.
- R7: The asynchronous reset `rst_ni` clears the history, the references, the count and the valid flags to zero. After reset, a first symbol of 0 therefore scores 4.
- R8: The count spans the full range from 0 (no tap matches) to 4 (all taps match) and never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x_valid_i | input | 1 | Symbol qualifier |
| x_sym_i | input | SYM_W | Incoming symbol |
| ref_we_i | input | 1 | Reference write request |
| ref_idx_i | input | IDX_W | Tap selected for the write |
| ref_sym_i | input | SYM_W | Reference symbol to write |
| y_valid_o | output | 1 | Count qualifier |
| y_cnt_o | output | CNT_W | Number of matching taps |

## Verification
A corrupted history register makes the counts wrong for the next three accepted symbols, and the first wrong count shows four cycles after the bad symbol enters. A reference that is wrong or was written when it should not have been makes the count off by one on every window where that tap decides the outcome. A valid flag that is dropped or duplicated in the stage chain shows as a missing or extra result, or a shifted one, within four cycles. The sweep streams every 4-symbol window under several patterns, so a single-tap fault cannot hide.

// File: rtl/pattern_corr_pkg.sv
package pattern_corr_pkg;
  function automatic int unsigned idx_bits(int unsigned taps);
    return (taps < 2) ? 1 : $clog2(taps);
  endfunction

  function automatic int unsigned cnt_bits(int unsigned taps);
    return $clog2(taps + 1);
  endfunction
endpackage

// File: rtl/corr_cell.sv
module corr_cell #(
  parameter int SYM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [SYM_W-1:0] ld_sym_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic [SYM_W-1:0] ref_o,
  output logic             hit_o
);
  logic [SYM_W-1:0] ref_q;
  logic             hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else if (ld_i) ref_q <= ld_sym_i;
  end

  // comparator stage: the only logic ahead of this register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= (sym_i == ref_q);
  end

  assign ref_o = ref_q;
  assign hit_o = hit_q;
endmodule

// File: rtl/corr_delay.sv
module corr_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] pipe_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign d_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/corr_acc_stage.sv
module corr_acc_stage #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] acc_i,
  input  logic             bit_i,
  input  logic             v_i,
  output logic [CNT_W-1:0] acc_o,
  output logic             v_o
);
  logic [CNT_W-1:0] acc_q;
  logic             v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      v_q   <= 1'b0;
    end else begin
      acc_q <= acc_i + CNT_W'(bit_i);
      v_q   <= v_i;
    end
  end

  assign acc_o = acc_q;
  assign v_o   = v_q;
endmodule

// File: rtl/pattern_corr.sv
module pattern_corr
  import pattern_corr_pkg::*;
#(
  parameter  int SYM_W    = 8,
  parameter  int NUM_TAPS = 4,
  localparam int IDX_W    = idx_bits(NUM_TAPS),
  localparam int CNT_W    = cnt_bits(NUM_TAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             x_valid_i,
  input  logic [SYM_W-1:0] x_sym_i,
  input  logic             ref_we_i,
  input  logic [IDX_W-1:0] ref_idx_i,
  input  logic [SYM_W-1:0] ref_sym_i,
  output logic             y_valid_o,
  output logic [CNT_W-1:0] y_cnt_o
);
  // x_hist[j] holds the symbol accepted j+1 valid inputs ago
  logic [SYM_W-1:0]          x_hist [NUM_TAPS-1];
  logic [NUM_TAPS-1:0]       hit;
  logic [NUM_TAPS-1:0]       hit_al;
  logic [NUM_TAPS*SYM_W-1:0] ref_flat;
  logic [NUM_TAPS-1:0][CNT_W-1:0] acc;
  logic [NUM_TAPS-1:0]       vld;
  logic                      v0_q;
  logic                      ld_ok;

  assign ld_ok = ref_we_i && !x_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < NUM_TAPS-1; j++) x_hist[j] <= '0;
    end else if (x_valid_i) begin
      x_hist[0] <= x_sym_i;
      for (int j = 1; j < NUM_TAPS-1; j++) x_hist[j] <= x_hist[j-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v0_q <= 1'b0;
    else         v0_q <= x_valid_i;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    logic [SYM_W-1:0] tap_sym;
    if (k == 0) begin : g_new
      assign tap_sym = x_sym_i;
    end else begin : g_old
      assign tap_sym = x_hist[k-1];
    end

    corr_cell #(.SYM_W(SYM_W)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (ld_ok && (ref_idx_i == IDX_W'(k))),
      .ld_sym_i (ref_sym_i),
      .sym_i    (tap_sym),
      .ref_o    (ref_flat[k*SYM_W +: SYM_W]),
      .hit_o    (hit[k])
    );

    // skew so tap k's bit meets the partial sum at stage k
    if (k < 2) begin : g_noskew
      assign hit_al[k] = hit[k];
    end else begin : g_skew
      corr_delay #(.W(1), .DEPTH(k-1)) u_skew (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (hit[k]),
        .d_o    (hit_al[k])
      );
    end
  end

  assign acc[0] = CNT_W'(hit_al[0]);
  assign vld[0] = v0_q;

  for (genvar j = 1; j < NUM_TAPS; j++) begin : g_acc
    corr_acc_stage #(.CNT_W(CNT_W)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .acc_i  (acc[j-1]),
      .bit_i  (hit_al[j]),
      .v_i    (vld[j-1]),
      .acc_o  (acc[j]),
      .v_o    (vld[j])
    );
  end

  assign y_cnt_o   = acc[NUM_TAPS-1];
  assign y_valid_o = vld[NUM_TAPS-1];
endmodule

// File: rtl/pattern_corr_chk.sv
module pattern_corr_chk #(
  parameter int SYM_W    = 8,
  parameter int NUM_TAPS = 4,
  parameter int IDX_W    = 2,
  parameter int CNT_W    = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      x_valid_i,
  input logic                      ref_we_i,
  input logic [IDX_W-1:0]          ref_idx_i,
  input logic [SYM_W-1:0]          ref_sym_i,
  input logic [NUM_TAPS*SYM_W-1:0] ref_flat,
  input logic                      y_valid_o,
  input logic [CNT_W-1:0]          y_cnt_o
);
  localparam int LAT = NUM_TAPS;

  logic [LAT-1:0] vhist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vhist_q <= '0;
    else         vhist_q <= {vhist_q[LAT-2:0], x_valid_i};
  end

  // R2
  a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vhist_q[LAT-1] |-> y_valid_o);

  // R3
  a_r3_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vhist_q[LAT-1] |-> !y_valid_o);

  // R5
  a_r5_ref_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_we_i && !x_valid_i && (int'(ref_idx_i) < NUM_TAPS)) |=>
      (ref_flat[int'($past(ref_idx_i))*SYM_W +: SYM_W] == $past(ref_sym_i)));

  // R6
  a_r6_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_we_i && x_valid_i) |=> $stable(ref_flat));

  // R8
  a_r8_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> (y_cnt_o <= CNT_W'(NUM_TAPS)));
endmodule

bind pattern_corr pattern_corr_chk #(
  .SYM_W    (SYM_W),
  .NUM_TAPS (NUM_TAPS),
  .IDX_W    (IDX_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .x_valid_i (x_valid_i),
  .ref_we_i  (ref_we_i),
  .ref_idx_i (ref_idx_i),
  .ref_sym_i (ref_sym_i),
  .ref_flat  (ref_flat),
  .y_valid_o (y_valid_o),
  .y_cnt_o   (y_cnt_o)
);

// File: tb/pattern_corr_bench.sv
module pattern_corr_bench;
  localparam int SYM_W = 2;
  localparam int NT    = 4;
  localparam int IDX_W = 2;
  localparam int CNT_W = 3;
  localparam int DUE   = 4;  // sampling edge + 3 further edges

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             xv = 1'b0;
  logic [SYM_W-1:0] xs = '0;
  logic             we = 1'b0;
  logic [IDX_W-1:0] widx = '0;
  logic [SYM_W-1:0] wsym = '0;
  logic             yv;
  logic [CNT_W-1:0] yc;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  int ref_m [NT];
  int hist [NT-1];
  int exp_q [$];
  int due_q [$];
  string tag_q [$];
  int e_v, d_v;
  string t_v;

  pattern_corr #(.SYM_W(SYM_W), .NUM_TAPS(NT)) u_pattern_corr (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .x_valid_i (xv),
    .x_sym_i   (xs),
    .ref_we_i  (we),
    .ref_idx_i (widx),
    .ref_sym_i (wsym),
    .y_valid_o (yv),
    .y_cnt_o   (yc)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && yv) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "output without input", 1, 0);
      end else begin
        e_v = exp_q.pop_front();
        d_v = due_q.pop_front();
        t_v = tag_q.pop_front();
        chk(cyc == d_v, "R2", "result cycle", cyc, d_v);
        chk(int'(yc) == e_v, t_v, "match count", int'(yc), e_v);
      end
    end
  end

  task automatic model_clear();
    for (int k = 0; k < NT; k++) ref_m[k] = 0;
    for (int j = 0; j < NT-1; j++) hist[j] = 0;
  endtask

  task automatic push_sym(int sym, string tag);
    int ev;
    string tg;
    ev = (sym == ref_m[0]) ? 1 : 0;
    for (int k = 1; k < NT; k++) ev += (hist[k-1] == ref_m[k]) ? 1 : 0;
    for (int j = NT-2; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = sym;
    tg = (ev == 0 || ev == NT) ? "R8" : tag;
    exp_q.push_back(ev);
    due_q.push_back(cyc + DUE);
    tag_q.push_back(tg);
  endtask

  task automatic send(int sym, string tag);
    @(posedge clk); #1;
    xv = 1'b1; xs = SYM_W'(sym); we = 1'b0;
    push_sym(sym, tag);
  endtask

  // valid symbol with a simultaneous write request (R6: must be dropped)
  task automatic send_blocked(int sym, int idx, int rsym);
    @(posedge clk); #1;
    xv = 1'b1; xs = SYM_W'(sym);
    we = 1'b1; widx = IDX_W'(idx); wsym = SYM_W'(rsym);
    push_sym(sym, "R6");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      xv = 1'b0; we = 1'b0;
    end
  endtask

  task automatic load_ref(int idx, int sym);
    @(posedge clk); #1;
    xv = 1'b0; we = 1'b1; widx = IDX_W'(idx); wsym = SYM_W'(sym);
    ref_m[idx] = sym;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit gap;
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    // R7: outputs cleared under reset
    chk(yv == 1'b0, "R7", "valid in reset", int'(yv), 0);
    chk(yc == '0, "R7", "count in reset", int'(yc), 0);
    rst_n = 1'b1;

    // R7: zeroed history and references give a full score for symbol 0
    send(0, "R7");
    send(1, "R1");
    idle(3);

    // R1/R4/R5: every 4-symbol window under several reference patterns
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < NT; k++) load_ref(k, (p * (k + 1) + k) & 3);
      idle(1);
      gap = 1'b0;
      for (int w = 0; w < 256; w++) begin
        for (int d = 3; d >= 0; d--) begin
          send((w >> (2 * d)) & 3, gap ? "R4" : (w == 0 && d == 3) ? "R5" : "R1");
          gap = 1'b0;
          if (((w + d) % 7) == 3) begin
            idle(1 + (w % 3));
            gap = 1'b1;
          end
        end
      end
      idle(2);
    end

    // R6: write request during a valid symbol has no effect
    for (int k = 0; k < NT; k++) load_ref(k, 1);
    send_blocked(2, 0, 3);
    for (int i = 0; i < NT; i++) send(1, "R6");
    idle(8);
    chk(exp_q.size() == 0, "R3", "results outstanding", exp_q.size(), 0);

    // R7: reset mid-run clears references and history
    rst_n = 1'b0;
    model_clear();
    repeat (2) @(posedge clk);
    #1;
    chk(yv == 1'b0, "R7", "valid after second reset", int'(yv), 0);
    rst_n = 1'b1;
    send(0, "R7");
    send(3, "R7");
    idle(8);
    chk(exp_q.size() == 0, "R3", "results outstanding", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule